// File: doc/BRIEF.md
# Multi-Format Slave Audio Serial Receiver

This block deserialises stereo audio from a serial port whose shift clock and frame clock both come from outside. It runs entirely on the incoming shift clock, samples serial data on each rising edge, and turns the bit stream into one left and one right two's-complement sample per frame. Each sample is sign-extended to 24 bits and announced by a one-cycle valid strobe.

A single shifter serves four framing styles: I2S, left-justified, right-justified and a pulse-marked DSP frame. It handles words of 16, 20 or 24 bits and frames of 48 or 64 shift clocks. In right-justified framing the first bit's position depends on both the half-frame length and the word length. One combination, 16-bit DSP framing in a 48-clock frame, is not supported. For that combination the block raises an error flag and captures nothing.

Top module: `stereo_slave_rx`

## Requirements
- R1: After reset, and for as long as reset is asserted, both sample outputs and both valid strobes are zero.
- R2: Left-justified (modeSel[1:0] = 1): the word's MSB is the bit sampled on the first rising shift-clock edge that sees the new frame-clock level. The frame clock low (after polarity) marks the left word and high marks the right word.
- R3: I2S (modeSel[1:0] = 0): the MSB is sampled one shift clock after the first edge that sees a frame-clock change. Channel assignment is the same as R2, and a word may finish in the first slot of the following half-frame.
- R4: Right-justified (modeSel[1:0] = 2): the LSB is the last bit of each half-frame. The MSB sits at half-frame position (half-frame length minus word length), counted from 0 at the frame-clock change.
- R5: DSP frame (modeSel[1:0] = 3): a frame-clock level of 1 (after polarity) for one shift clock marks the frame. The left MSB is sampled on the next clock, and the right MSB on the clock right after the left LSB.
- R6: wordSel selects the word length: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 give 24 bits. The captured word appears on the 24-bit output sign-extended from its MSB.
- R7: frameSel selects the frame length: 0 gives 48 shift clocks (half-frame 24), and 1 gives 64 (half-frame 32).
- R8: modeSel[2] = 1 inverts the frame clock before any decoding.
- R9: The valid strobe of a channel is high for exactly one cycle. It rises right after the rising edge that samples that word's LSB, once per completed word. Sample outputs hold their value between strobes.
- R10: While DSP framing, 16-bit words and a 48-clock frame are selected together, cfgError is 1, no valid strobe is raised and the sample outputs keep their previous values. For every other setting cfgError is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Shift clock from the external master; data sampled on rising edges |
| rstN | input | 1 | Asynchronous active-low reset |
| frameClk | input | 1 | Frame clock or DSP frame pulse |
| serData | input | 1 | Serial audio data, MSB first |
| modeSel | input | 3 | [1:0] framing style, [2] frame-clock polarity inversion |
| wordSel | input | 2 | Word length select |
| frameSel | input | 1 | Frame length select (48 or 64 shift clocks) |
| leftSample | output | 24 | Last left word, sign-extended |
| leftValid | output | 1 | One-cycle strobe for a new left word |
| rightSample | output | 24 | Last right word, sign-extended |
| rightValid | output | 1 | One-cycle strobe for a new right word |
| cfgError | output | 1 | Unsupported framing combination selected |

## Verification
The hardest situation to reach is a word that crosses a half-frame boundary. This happens in I2S with 24-bit words in a 48-clock frame, where the right word's LSB arrives in the first slot of the next frame. The bench builds every frame bit by bit from a circular start-offset model and sends two consecutive frames, so that wrapped bit is delivered. It then checks both the captured value and the exact frame slot in which each strobe appeared. The unsupported DSP setting is reached without a reset after a good capture, so that the bench can see at the ports that the held samples survive it.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int POS_W    = 6;
  localparam int CNT_W    = 5;
  localparam int POS_MAX  = (1 << POS_W) - 1;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic commitL;
    logic commitR;
  } rxStrobe_t;

  function automatic logic [CNT_W-1:0] wordLenOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(20);
      default: return CNT_W'(24);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] halfLenOf(input logic sel);
    return sel ? POS_W'(32) : POS_W'(24);
  endfunction

  function automatic logic [SAMPLE_W-1:0] signExtend(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [1:0] sel);
    case (sel)
      2'd0:    return {{(SAMPLE_W-16){raw[15]}}, raw[15:0]};
      2'd1:    return {{(SAMPLE_W-20){raw[19]}}, raw[19:0]};
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/stereo_rx_ctrl.sv
module stereo_rx_ctrl
  import stereo_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic [2:0] modeSel,
  input  logic [1:0] wordSel,
  input  logic       frameSel,
  output rxStrobe_t  strobe,
  output logic       cfgErr
);

  fmt_e             fmt;
  logic             fcEff;
  logic             fcPrev;
  logic             edgeSeen;
  logic             pulseRose;
  logic             active;
  logic             wordIsRight;
  logic             rightPend;
  logic             startNow;
  logic             startChanR;
  logic             lastBit;
  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] curPos;
  logic [POS_W-1:0] halfLen;
  logic [POS_W-1:0] startPos;
  logic [CNT_W-1:0] wordLen;
  logic [CNT_W-1:0] bitCnt;

  assign fmt      = fmt_e'(modeSel[1:0]);
  assign fcEff    = frameClk ^ modeSel[2];
  assign edgeSeen = fcEff != fcPrev;
  assign wordLen  = wordLenOf(wordSel);
  assign halfLen  = halfLenOf(frameSel);
  assign startPos = halfLen - POS_W'(wordLen);
  assign cfgErr   = (fmt == FMT_DSP) && (wordSel == 2'd0) && !frameSel;
  assign lastBit  = active && (bitCnt == wordLen - CNT_W'(1));

  // position of the bit being sampled, counted from the frame-clock change
  always_comb begin
    if (edgeSeen)
      curPos = '0;
    else if (posCnt == POS_W'(POS_MAX))
      curPos = posCnt;
    else
      curPos = posCnt + POS_W'(1);
  end

  always_comb begin
    startNow   = 1'b0;
    startChanR = fcEff;
    unique case (fmt)
      FMT_LJ:  startNow = edgeSeen;
      FMT_I2S: startNow = (curPos == POS_W'(1));
      FMT_RJ:  startNow = (curPos == startPos);
      FMT_DSP: begin
        startNow   = rightPend | pulseRose;
        startChanR = rightPend;
      end
    endcase
  end

  always_comb begin
    strobe = '0;
    if (!cfgErr) begin
      if (startNow) begin
        strobe.load = 1'b1;
      end else if (active) begin
        strobe.shift   = 1'b1;
        strobe.commitL = lastBit && !wordIsRight;
        strobe.commitR = lastBit && wordIsRight;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fcPrev      <= 1'b0;
      posCnt      <= POS_W'(POS_MAX);
      pulseRose   <= 1'b0;
      active      <= 1'b0;
      wordIsRight <= 1'b0;
      rightPend   <= 1'b0;
      bitCnt      <= '0;
    end else begin
      fcPrev    <= fcEff;
      posCnt    <= curPos;
      pulseRose <= fcEff & ~fcPrev;
      if (cfgErr) begin
        active    <= 1'b0;
        rightPend <= 1'b0;
      end else if (startNow) begin
        active      <= 1'b1;
        bitCnt      <= CNT_W'(1);
        wordIsRight <= startChanR;
        rightPend   <= 1'b0;
      end else if (active) begin
        if (lastBit) begin
          active    <= 1'b0;
          rightPend <= (fmt == FMT_DSP) && !wordIsRight;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  // R4
  rj_lsb_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmt == FMT_RJ && (strobe.commitL || strobe.commitR)) |-> (curPos == halfLen - POS_W'(1)));

  // R5
  dsp_right_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmt == FMT_DSP && strobe.commitL) |=> (strobe.load || cfgErr || fmt != FMT_DSP));

endmodule

// File: rtl/stereo_rx_datapath.sv
module stereo_rx_datapath
  import stereo_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serData,
  input  rxStrobe_t           strobe,
  input  logic [1:0]          wordSel,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                leftValid,
  output logic                rightValid
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] nextShift;
  logic [SAMPLE_W-1:0] extended;

  assign nextShift = strobe.load ? {{(SAMPLE_W-1){1'b0}}, serData}
                                 : {shiftReg[SAMPLE_W-2:0], serData};
  assign extended  = signExtend(nextShift, wordSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      leftValid   <= 1'b0;
      rightValid  <= 1'b0;
    end else begin
      if (strobe.load || strobe.shift)
        shiftReg <= nextShift;
      if (strobe.commitL)
        leftSample <= extended;
      if (strobe.commitR)
        rightSample <= extended;
      leftValid  <= strobe.commitL;
      rightValid <= strobe.commitR;
    end
  end

  // R9
  left_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |=> !leftValid);

  // R9
  right_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rightValid |=> !rightValid);

  // R9
  left_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !leftValid |-> $stable(leftSample));

  // R9
  right_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rightValid |-> $stable(rightSample));

  // R6
  sign16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid && wordSel == 2'd0 && $stable(wordSel))
      |-> (leftSample[SAMPLE_W-1:16] == {(SAMPLE_W-16){leftSample[15]}}));

endmodule

// File: rtl/stereo_slave_rx.sv
module stereo_slave_rx
  import stereo_rx_pkg::*;
(
  input  logic                sck,
  input  logic                rstN,
  input  logic                frameClk,
  input  logic                serData,
  input  logic [2:0]          modeSel,
  input  logic [1:0]          wordSel,
  input  logic                frameSel,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic                leftValid,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                rightValid,
  output logic                cfgError
);

  rxStrobe_t strobe;

  stereo_rx_ctrl u_ctrl (
    .clk      (sck),
    .rstN     (rstN),
    .frameClk (frameClk),
    .modeSel  (modeSel),
    .wordSel  (wordSel),
    .frameSel (frameSel),
    .strobe   (strobe),
    .cfgErr   (cfgError)
  );

  stereo_rx_datapath u_data (
    .clk         (sck),
    .rstN        (rstN),
    .serData     (serData),
    .strobe      (strobe),
    .wordSel     (wordSel),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .leftValid   (leftValid),
    .rightValid  (rightValid)
  );

  // R10
  err_silent_chk: assert property (@(posedge sck) disable iff (!rstN)
    cfgError |=> (!leftValid && !rightValid));

endmodule

// File: tb/stereo_slave_rx_bench.sv
module stereo_slave_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NVEC       = 11;

  // fields: mode[53:51] wsel[50:49] fsel[48] left[47:24] right[23:0]
  localparam logic [53:0] VECS [NVEC] = '{
    {3'd0, 2'd0, 1'b1, 24'h001234, 24'h008001},
    {3'd1, 2'd1, 1'b0, 24'h07ABCD, 24'h080000},
    {3'd2, 2'd2, 1'b1, 24'h800001, 24'h123456},
    {3'd2, 2'd0, 1'b0, 24'h00FFFF, 24'h000001},
    {3'd3, 2'd2, 1'b0, 24'hA5A5A5, 24'h5A5A5A},
    {3'd3, 2'd0, 1'b1, 24'h008000, 24'h007FFF},
    {3'd0, 2'd2, 1'b0, 24'hC00003, 24'h3FFFFC},
    {3'd5, 2'd0, 1'b1, 24'h0000F0, 24'h00F00F},
    {3'd6, 2'd1, 1'b1, 24'h09ABCD, 24'h012345},
    {3'd0, 2'd3, 1'b1, 24'h876543, 24'h010203},
    {3'd7, 2'd1, 1'b1, 24'h0FEDCB, 24'h001234}
  };

  logic        sck = 1'b0;
  logic        rstN = 1'b0;
  logic        fc = 1'b0;
  logic        sd = 1'b0;
  logic [2:0]  mode = 3'd1;
  logic [1:0]  wsel = 2'd0;
  logic        fsel = 1'b1;
  logic [23:0] leftSample, rightSample;
  logic        leftValid, rightValid, cfgError;

  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  int          lCount, rCount, lastLPos, lastRPos;
  logic [23:0] lastL, lastR;

  stereo_slave_rx u_stereo_slave_rx (
    .sck         (sck),
    .rstN        (rstN),
    .frameClk    (fc),
    .serData     (sd),
    .modeSel     (mode),
    .wordSel     (wsel),
    .frameSel    (fsel),
    .leftSample  (leftSample),
    .leftValid   (leftValid),
    .rightSample (rightSample),
    .rightValid  (rightValid),
    .cfgError    (cfgError)
  );

  function automatic int wordLenB(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : 24;
  endfunction

  function automatic int startOf(input logic [1:0] f, input int w, input int fl, input bit right);
    int half = fl / 2;
    case (f)
      2'd0:    return right ? half + 1 : 1;
      2'd1:    return right ? half : 0;
      2'd2:    return right ? fl - w : half - w;
      default: return right ? 1 + w : 1;
    endcase
  endfunction

  function automatic logic bitFor(input logic [1:0] f, input int w, input int fl,
                                  input logic [23:0] l, input logic [23:0] r, input int g);
    int kl = (g - startOf(f, w, fl, 1'b0) + fl) % fl;
    int kr = (g - startOf(f, w, fl, 1'b1) + fl) % fl;
    if (kl < w) return l[w-1-kl];
    if (kr < w) return r[w-1-kr];
    return 1'b0;
  endfunction

  function automatic logic fcFor(input logic [2:0] m, input int fl, input int g);
    logic lvl = (m[1:0] == 2'd3) ? (g == 0) : (g >= fl / 2);
    return lvl ^ m[2];
  endfunction

  function automatic logic [23:0] expSample(input logic [23:0] raw, input int w);
    logic [23:0] m = (24'h1 << w) - 24'h1;
    logic [23:0] t = raw & m;
    if (t[w-1]) t = t | ~m;
    return t;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic fcV, input logic sdV, input int g);
    fc = fcV;
    sd = sdV;
    #(HALF);
    sck = 1'b1;
    #(HALF / 2);
    if (leftValid) begin
      lCount++;
      lastL    = leftSample;
      lastLPos = g;
    end
    if (rightValid) begin
      rCount++;
      lastR    = rightSample;
      lastRPos = g;
    end
    #(HALF - HALF / 2);
    sck = 1'b0;
  endtask

  function automatic logic idleFc(input logic [2:0] m);
    return ((m[1:0] == 2'd3) ? 1'b0 : 1'b1) ^ m[2];
  endfunction

  task automatic clearMon();
    lCount = 0; rCount = 0; lastLPos = -1; lastRPos = -1; lastL = '0; lastR = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(idleFc(mode), 1'b0, -1);
    tick(idleFc(mode), 1'b0, -1);
    rstN = 1'b1;
  endtask

  task automatic sendFrames(input logic [23:0] l, input logic [23:0] r, input int n);
    int w  = wordLenB(wsel);
    int fl = fsel ? 64 : 48;
    for (int i = 0; i < 4; i++) tick(idleFc(mode), 1'b0, -1);
    for (int f = 0; f < n; f++)
      for (int g = 0; g < fl; g++)
        tick(fcFor(mode, fl, g), bitFor(mode[1:0], w, fl, l, r, g), g);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    clearMon();
    doReset();
    check("R1", "leftSample", 32'(leftSample), 32'h0);
    check("R1", "rightSample", 32'(rightSample), 32'h0);
    check("R1", "leftValid", 32'(leftValid), 32'h0);
    check("R1", "rightValid", 32'(rightValid), 32'h0);

    // vector table: formats R2 R3 R4 R5, lengths R6 R7, polarity R8
    for (int i = 0; i < NVEC; i++) begin
      logic [53:0] vv = VECS[i];
      logic [23:0] l  = vv[47:24];
      logic [23:0] r  = vv[23:0];
      int    w, fl;
      string req;
      mode = vv[53:51];
      wsel = vv[50:49];
      fsel = vv[48];
      w  = wordLenB(wsel);
      fl = fsel ? 64 : 48;
      case (mode[1:0])
        2'd0:    req = "R3";
        2'd1:    req = "R2";
        2'd2:    req = "R4";
        default: req = "R5";
      endcase
      doReset();
      clearMon();
      sendFrames(l, r, 2);
      check(req, "left value", 32'(lastL), 32'(expSample(l, w)));
      check(req, "right value", 32'(lastR), 32'(expSample(r, w)));
      check(req, "left end slot", 32'(lastLPos), 32'((startOf(mode[1:0], w, fl, 1'b0) + w - 1) % fl));
      check(req, "right end slot", 32'(lastRPos), 32'((startOf(mode[1:0], w, fl, 1'b1) + w - 1) % fl));
      check("R10", "cfgError clear", 32'(cfgError), 32'h0);
    end

    // R9: exactly one strobe per word, value held afterwards
    mode = 3'd1; wsel = 2'd0; fsel = 1'b1;
    doReset();
    clearMon();
    sendFrames(24'h004321, 24'h00BCDE, 2);
    for (int i = 0; i < 20; i++) tick(idleFc(mode), 1'b1, -1);
    check("R9", "left strobe count", 32'(lCount), 32'd2);
    check("R9", "right strobe count", 32'(rCount), 32'd2);
    check("R9", "left held", 32'(leftSample), 32'h004321);
    check("R9", "right held", 32'(rightSample), 32'hFFBCDE);

    // R10: unsupported combination, no reset in between
    mode = 3'd3; wsel = 2'd0; fsel = 1'b0;
    tick(idleFc(mode), 1'b0, -1);
    check("R10", "cfgError set", 32'(cfgError), 32'h1);
    clearMon();
    sendFrames(24'h001111, 24'h002222, 2);
    check("R10", "no left strobe", 32'(lCount), 32'd0);
    check("R10", "no right strobe", 32'(rCount), 32'd0);
    check("R10", "left kept", 32'(leftSample), 32'h004321);
    check("R10", "right kept", 32'(rightSample), 32'hFFBCDE);
    fsel = 1'b1;
    tick(idleFc(mode), 1'b0, -1);
    check("R10", "cfgError cleared", 32'(cfgError), 32'h0);

    // R1: reset during operation clears outputs at once
    rstN = 1'b0;
    #1;
    check("R1", "left cleared", 32'(leftSample), 32'h0);
    check("R1", "right cleared", 32'(rightSample), 32'h0);
    rstN = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule